// File: doc/BRIEF.md
# Reflected CRC-16 Signature Engine

This block computes a 16-bit frame check signature over a stream of bytes written by software through a small register bus. It uses the generator polynomial x^16 + x^12 + x^5 + 1. Bits are shifted in least-significant first, and the accumulator is preset to all ones. This gives the usual HDLC-style frame check: software presets the accumulator, writes the payload, and takes the one's complement of the accumulator as the check sequence.

Two write ports feed data. One takes bytes as written. The other mirrors the bit order inside every byte before processing, which suits data that was captured MSB-first. Two read views expose the accumulator: one as stored, one with all sixteen bits mirrored. The accumulator can be loaded with any value, as a full word or one byte at a time.

The bus is a valid/ready write channel. `bus_ready` is held high, so the engine never applies back-pressure: every cycle with `bus_valid` high and `bus_write` high is one accepted write, and writes may follow one another on consecutive cycles. Reads are combinational on `bus_addr` and need no handshake.

Top module: `sig16_engine`

## Requirements
- R1: After reset, and again after any later reset, the accumulator holds 0xFFFF.
- R2: Each data bit d updates the accumulator c as follows. A feedback bit equal to c[0] XOR d is formed, c is shifted right by one, and 0x8408 is XORed in when the feedback bit is 1. With a preset accumulator, byte writes of ASCII "123456789" leave 0x6F91, whose complement is 0x906E. An all-zero accumulator fed zero data stays zero.
- R3: A byte write (`bus_word`=0) to byte address 0 or 1 processes one byte, LSB first. Address bit 0 selects the lane: 0 takes `bus_wdata[7:0]` and 1 takes `bus_wdata[15:8]`. The other lane is ignored.
- R4: A word write (`bus_word`=1) to address 0 processes `bus_wdata[7:0]` and then `bus_wdata[15:8]` in the same clock. It gives the same result as two byte writes in that order.
- R5: Writes to byte address 2 or 3 behave as R3/R4, except that each byte is bit-mirrored (bit i taken to bit 7-i) before processing.
- R6: A read at byte address 6 returns the accumulator with bit i placed at bit 15-i.
- R7: A word write to byte address 4 loads `bus_wdata` into the accumulator. A read at byte address 4 returns the accumulator.
- R8: A byte write to address 4 replaces only accumulator bits [7:0], with `bus_wdata[7:0]`. A byte write to address 5 replaces only bits [15:8], with `bus_wdata[15:8]`.
- R9: Writes to byte addresses 6 and 7 leave the accumulator unchanged.
- R10: `bus_ready` is always 1. One write is accepted on every cycle with `bus_valid` and `bus_write` both high. A cycle without both leaves the accumulator unchanged.
- R11: Reads at byte addresses 0 through 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Write request present |
| bus_ready | output | 1 | Write accepted (always 1) |
| bus_write | input | 1 | Request is a write |
| bus_word | input | 1 | 1: 16-bit write, 0: byte write |
| bus_addr | input | 3 | Byte address within the block |
| bus_wdata | input | 16 | Write data, byte lanes by address bit 0 |
| bus_rdata | output | 16 | Read data for `bus_addr` |

## Verification
Any corruption of the accumulator, whether from a wrong feedback tap, a bit-order mistake or a lane mix-up, shows up at address 4 in the cycle after the write that caused it. It stays visible in every later read, because the signature never heals. The mirrored view at address 6 exposes the same fault in the same cycle. A reference model that tracks the accumulator is therefore compared on every clock with whichever view is addressed. Fixed check values, such as the standard nine-digit check string, pin down polynomial, direction and preset independently of that model.

// File: rtl/sig16_pkg.sv
package sig16_pkg;
  localparam int CRC_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int LANES     = CRC_W / BYTE_W;
  localparam int LANE_IW   = $clog2(LANES);
  localparam int ADDR_W    = LANE_IW + 2;
  localparam logic [CRC_W-1:0] POLY_REFL = 16'h8408;
  localparam logic [CRC_W-1:0] PRESET    = 16'hFFFF;

  typedef enum logic [1:0] {
    OFS_DATA       = 2'd0,
    OFS_DATA_MIRR  = 2'd1,
    OFS_ACC        = 2'd2,
    OFS_ACC_MIRR   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sig16_bitrev.sv
module sig16_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/sig16_bytestep.sv
// Folds DATA_W input bits, LSB first, into a reflected CRC accumulator.
module sig16_bytestep #(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] chain [0:DATA_W];

  assign chain[0] = crc_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fb;
    assign fb = chain[i][0] ^ data_in[i];
    assign chain[i+1] = (chain[i] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_out = chain[DATA_W];
endmodule

// File: rtl/sig16_engine.sv
module sig16_engine
  import sig16_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic                bus_word,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CRC_W-1:0]    bus_wdata,
  output logic [CRC_W-1:0]    bus_rdata
);
  logic [CRC_W-1:0]   acc_q;
  logic [CRC_W-1:0]   acc_d;
  logic [CRC_W-1:0]   acc_mirr;
  logic               wr_fire;
  reg_sel_e           sel;
  logic [LANE_IW-1:0] lane_idx;
  logic               mirr_in;

  logic [BYTE_W-1:0] lane_raw  [LANES];
  logic [BYTE_W-1:0] lane_rev  [LANES];
  logic [BYTE_W-1:0] lane_data [LANES];
  logic [BYTE_W-1:0] step_in   [LANES];
  logic [CRC_W-1:0]  step_crc  [0:LANES];

  assign bus_ready = 1'b1;
  assign wr_fire   = bus_valid & bus_ready & bus_write;
  assign sel       = reg_sel_e'(bus_addr[ADDR_W-1:LANE_IW]);
  assign lane_idx  = bus_addr[LANE_IW-1:0];
  assign mirr_in   = (sel == OFS_DATA_MIRR);

  // Per-lane input conditioning: optional bit mirroring inside each byte.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_raw[l] = bus_wdata[l*BYTE_W +: BYTE_W];
    sig16_bitrev #(.W(BYTE_W)) u_rev (
      .din  (lane_raw[l]),
      .dout (lane_rev[l])
    );
    assign lane_data[l] = mirr_in ? lane_rev[l] : lane_raw[l];
  end

  // Cascade of byte steps: a word write runs all lanes low to high,
  // a byte write uses only the first stage fed from the addressed lane.
  assign step_crc[0] = acc_q;
  for (genvar s = 0; s < LANES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign step_in[s] = bus_word ? lane_data[0] : lane_data[lane_idx];
    end else begin : g_rest
      assign step_in[s] = lane_data[s];
    end
    sig16_bytestep #(.CRC_W(CRC_W), .DATA_W(BYTE_W), .POLY(POLY_REFL)) u_step (
      .crc_in  (step_crc[s]),
      .data_in (step_in[s]),
      .crc_out (step_crc[s+1])
    );
  end

  always_comb begin
    acc_d = acc_q;
    if (wr_fire) begin
      unique case (sel)
        OFS_DATA, OFS_DATA_MIRR: begin
          acc_d = bus_word ? step_crc[LANES] : step_crc[1];
        end
        OFS_ACC: begin
          if (bus_word) begin
            acc_d = bus_wdata;
          end else begin
            acc_d[lane_idx*BYTE_W +: BYTE_W] = bus_wdata[lane_idx*BYTE_W +: BYTE_W];
          end
        end
        default: acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= PRESET;
    else        acc_q <= acc_d;
  end

  sig16_bitrev #(.W(CRC_W)) u_acc_rev (
    .din  (acc_q),
    .dout (acc_mirr)
  );

  always_comb begin
    unique case (sel)
      OFS_ACC:      bus_rdata = acc_q;
      OFS_ACC_MIRR: bus_rdata = acc_mirr;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sig16_checker.sv
module sig16_checker
  import sig16_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CRC_W-1:0]  bus_wdata,
  input logic [CRC_W-1:0]  acc_q
);
  logic wr;
  assign wr = bus_valid && bus_write;

  AST_PRESET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_q == PRESET)); // R1

  AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(acc_q)); // R10

  AST_MIRROR_VIEW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr[ADDR_W-1:LANE_IW] == 2'd3) |=> $stable(acc_q)); // R9

  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_word && bus_addr[ADDR_W-1:LANE_IW] == 2'd2) |=> (acc_q == $past(bus_wdata))); // R7

  AST_LOW_BYTE_LOAD_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !bus_word && bus_addr == 3'd4) |=>
      (acc_q[15:8] == $past(acc_q[15:8]) && acc_q[7:0] == $past(bus_wdata[7:0]))); // R8
endmodule

bind sig16_engine sig16_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_word  (bus_word),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .acc_q     (acc_q)
);

// File: tb/test_sig16_engine.sv
`timescale 1ns/1ps
module test_sig16_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic        bus_word = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] mdl = 16'hFFFF;
  string msg_str = "123456789";

  always #2.5 clk = ~clk;

  sig16_engine i_sig16_engine (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[15-i];
    return r;
  endfunction

  function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] b);
    int v = c;
    for (int i = 0; i < 8; i++) begin
      if (((v % 2) != 0) != b[i]) v = (v / 2) ^ 'h8408;
      else v = v / 2;
    end
    return v[15:0];
  endfunction

  // Reference model, updated on the same edge as the design.
  always @(posedge clk) begin
    if (!rst_n) mdl <= 16'hFFFF;
    else if (bus_valid && bus_write) begin
      logic [7:0] lo, hi;
      lo = bus_wdata[7:0];
      hi = bus_wdata[15:8];
      case (bus_addr[2:1])
        2'd0, 2'd1: begin
          if (bus_addr[2:1] == 2'd1) begin lo = rev8(lo); hi = rev8(hi); end
          if (bus_word) mdl <= fold(fold(mdl, lo), hi);
          else          mdl <= fold(mdl, bus_addr[0] ? hi : lo);
        end
        2'd2: begin
          if (bus_word) mdl <= bus_wdata;
          else if (bus_addr[0]) mdl <= {hi, mdl[7:0]};
          else mdl <= {mdl[15:8], lo};
        end
        default: ;
      endcase
    end
  end

  // Cycle-by-cycle comparison of the addressed view against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] exp;
      string tag;
      case (bus_addr[2:1])
        2'd2: begin exp = mdl;        tag = "R7"; end
        2'd3: begin exp = rev16(mdl); tag = "R6"; end
        default: begin exp = 16'h0;   tag = "R11"; end
      endcase
      checks++;
      if (bus_rdata !== exp) begin
        errors++;
        $display("FAIL %s model compare addr=%0d got=%h exp=%h", tag, bus_addr, bus_rdata, exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic w, input logic [15:0] d);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp || bus_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s addr=%0d got=%h exp=%h ready=%b", tag, a, bus_rdata, exp, bus_ready);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_rd(3'd4, 16'hFFFF, "R1");
    expect_rd(3'd6, 16'hFFFF, "R6");

    // R2 / R10: check string as back-to-back byte writes on the low lane.
    for (int i = 0; i < 9; i++) wr(3'd0, 1'b0, {8'h5A, msg_str[i]});
    expect_rd(3'd4, 16'h6F91, "R2");
    expect_rd(3'd6, 16'h89F6, "R6");

    // R4: word writes, low byte first, then a final byte.
    wr(3'd4, 1'b1, 16'hFFFF);
    for (int i = 0; i < 4; i++) wr(3'd0, 1'b1, {msg_str[2*i+1], msg_str[2*i]});
    wr(3'd0, 1'b0, {8'h00, msg_str[8]});
    expect_rd(3'd4, 16'h6F91, "R4");

    // R3: byte writes on the high lane with junk on the low lane.
    wr(3'd4, 1'b1, 16'hFFFF);
    for (int i = 0; i < 9; i++) wr(3'd1, 1'b0, {msg_str[i], 8'hA5});
    expect_rd(3'd4, 16'h6F91, "R3");

    // R5: mirrored data port, word then byte.
    wr(3'd4, 1'b1, 16'hFFFF);
    for (int i = 0; i < 4; i++) wr(3'd2, 1'b1, {rev8(msg_str[2*i+1]), rev8(msg_str[2*i])});
    wr(3'd3, 1'b0, {rev8(msg_str[8]), 8'h3C});
    expect_rd(3'd4, 16'h6F91, "R5");

    // R2 corner: zero accumulator with zero data stays zero.
    wr(3'd4, 1'b1, 16'h0000);
    wr(3'd0, 1'b1, 16'h0000);
    expect_rd(3'd4, 16'h0000, "R2");

    // R7 / R8: direct loads.
    wr(3'd4, 1'b1, 16'h1234);
    expect_rd(3'd4, 16'h1234, "R7");
    wr(3'd4, 1'b0, 16'h77AB);
    expect_rd(3'd4, 16'h12AB, "R8");
    wr(3'd5, 1'b0, 16'hCD66);
    expect_rd(3'd4, 16'hCDAB, "R8");

    // R9: writes to the mirrored result view are ignored.
    wr(3'd6, 1'b1, 16'h0000);
    wr(3'd7, 1'b0, 16'h0000);
    expect_rd(3'd4, 16'hCDAB, "R9");

    // R10: write strobe without valid has no effect.
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b1; bus_word = 1'b1; bus_addr = 3'd0; bus_wdata = 16'hBEEF;
    repeat (3) @(posedge clk);
    expect_rd(3'd4, 16'hCDAB, "R10");

    // R11: data-in addresses read zero.
    expect_rd(3'd0, 16'h0000, "R11");
    expect_rd(3'd2, 16'h0000, "R11");

    // R1: reset in mid-stream restores the preset.
    wr(3'd0, 1'b1, 16'h1111);
    do_reset();
    expect_rd(3'd4, 16'hFFFF, "R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule